// File: doc/BRIEF.md
# Reference-Gated Oscillator Frequency Counter

This block measures how fast one on-chip oscillator runs. It counts that oscillator's edges over a gate window. The window is timed by a low-rate reference, either the 32.768 kHz crystal tick or an external clock tick. All oscillator and reference edges arrive as single-cycle enables in the system clock domain.

The window length is set by two codes. A 4-bit exponent gives a power-of-two prescale. An 8-bit code then gives a further divide by code+1. A 3-bit source code picks which of five oscillator enables is counted. The command engine pulses `start`, waits for `done`, and reads the 16-bit result as a low byte and a high byte. Both bytes change together at the end of each window, so the two halves of a read always belong to the same measurement.

All pins are plain control and status pins. There is no streaming data path, so there is no valid/ready handshake and no back-pressure. The result registers simply hold until the next window closes.

Top module: `osc_gate_counter`

## Requirements
- R1: After reset, `busy` and `done` are 0 and both result bytes are 00h.
- R2: A `start` pulse while idle, with reference code 01 (external tick) or 10 (crystal tick), is accepted. `busy` is 1 from the next cycle, and `start` pulses during a measurement have no effect.
- R3: With reference code 00 or 11, `start` is ignored: `busy` stays 0, and `done` and both result bytes keep their values.
- R4: The window opens on the first tick of the chosen reference that occurs in a cycle after the accepted `start`. Ticks of the reference that was not chosen have no effect.
- R5: The window lasts 2^n·(d+1) periods of the chosen reference, where n is `pre_exp` (0..15) and d is `div_code` (0..255). It closes on the tick that ends the last period.
- R6: The result equals the number of cycles in the window, from the opening tick cycle up to but not including the closing tick cycle, in which the chosen oscillator enable is high. Source code k in 1..5 selects `osc_tick[k-1]`.
- R7: Source codes 0, 6 and 7 count nothing. The measurement still runs its full window and completes with a result of 0.
- R8: The count saturates at FFFFh and never wraps.
- R9: The result bytes change only in the cycle the window closes, and both change together. `cnt_lo` carries result bits 7:0 and `cnt_hi` carries bits 15:8. While `busy` is 1 they hold the previous result.
- R10: `done` goes to 1 in the same cycle that `busy` returns to 0. It stays 1 until the next accepted `start` clears it, and it is never 1 while `busy` is 1.
- R11: The reference code, exponent, divider code and source code are captured when `start` is accepted. Changing these inputs during a measurement has no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Measurement request pulse from the command engine |
| ref_sel | input | 2 | Reference choice: 00 off, 01 external tick, 10 crystal tick, 11 unused |
| pre_exp | input | 4 | Prescale exponent n; prescale ratio 2^n |
| div_code | input | 8 | Divider code d; divide ratio d+1 |
| src_sel | input | 3 | Oscillator source code; 1..5 valid, 0/6/7 none |
| xtal_tick | input | 1 | One-cycle enable per crystal reference edge |
| ext_tick | input | 1 | One-cycle enable per external reference edge |
| osc_tick | input | 5 | One-cycle enables per edge of the five oscillators |
| busy | output | 1 | Measurement in progress (armed or gating) |
| done | output | 1 | Last measurement complete, result valid |
| cnt_lo | output | 8 | Result bits 7:0 |
| cnt_hi | output | 8 | Result bits 15:8 |

## Verification
The bench targets the edges of the window. One case puts a reference tick in the very cycle of `start`; a design that opened on that tick would count one reference period too many. The shortest window (n=0, d=0) and the largest exponent would expose an off-by-one in the prescale mask or the divider compare, showing up as a count short or long by whole periods. A full-rate 65536-cycle window forces saturation, where a wrapping counter would return 0000h. Other cases change the inputs in mid-flight, send spurious starts, toggle the unused reference, and use the off and unused reference codes. A design that sampled the inputs late, restarted on a second start, or armed without a reference would time the wrong window or hang with `busy` stuck high.

// File: rtl/ofc_pkg.sv
package ofc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ARM  = 2'd1,
    ST_GATE = 2'd2
  } ofc_state_e;

  localparam logic [1:0] REF_EXT  = 2'b01;
  localparam logic [1:0] REF_XTAL = 2'b10;
endpackage

// File: rtl/ofc_src_mux.sv
module ofc_src_mux #(
  parameter int NSRC  = 5,
  parameter int SEL_W = 3
) (
  input  logic [NSRC-1:0]  osc_tick,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  logic [NSRC-1:0] hit;

  // Code k (1..NSRC) picks enable k-1; every other code matches nothing.
  for (genvar i = 0; i < NSRC; i++) begin : g_hit
    assign hit[i] = osc_tick[i] && (sel == SEL_W'(i + 1));
  end

  assign tick = |hit;
endmodule

// File: rtl/ofc_gate_timer.sv
module ofc_gate_timer #(
  parameter int PRE_W = 4,
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             adv,
  input  logic [PRE_W-1:0] exp_code,
  input  logic [DIV_W-1:0] div_code,
  output logic             last
);
  localparam int PC_W = (1 << PRE_W) - 1;

  logic [PC_W-1:0]  pre_cnt;
  logic [PC_W-1:0]  pre_mask;
  logic [DIV_W-1:0] div_cnt;
  logic             pre_wrap;

  assign pre_mask = ~({PC_W{1'b1}} << exp_code);
  assign pre_wrap = adv && (pre_cnt == pre_mask);
  assign last     = pre_wrap && (div_cnt == div_code);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_cnt <= '0;
      div_cnt <= '0;
    end else if (clear) begin
      pre_cnt <= '0;
      div_cnt <= '0;
    end else if (adv) begin
      pre_cnt <= pre_wrap ? '0 : pre_cnt + 1'b1;
      if (pre_wrap) div_cnt <= div_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/ofc_sat_counter.sv
module ofc_sat_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         inc,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (clear) begin
      q <= {{(W-1){1'b0}}, inc};
    end else if (inc && (q != {W{1'b1}})) begin
      q <= q + 1'b1;
    end
  end
endmodule

// File: rtl/osc_gate_counter.sv
module osc_gate_counter
  import ofc_pkg::*;
#(
  parameter int PRE_W = 4,
  parameter int DIV_W = 8,
  parameter int SEL_W = 3,
  parameter int NSRC  = 5,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [1:0]       ref_sel,
  input  logic [PRE_W-1:0] pre_exp,
  input  logic [DIV_W-1:0] div_code,
  input  logic [SEL_W-1:0] src_sel,
  input  logic             xtal_tick,
  input  logic             ext_tick,
  input  logic [NSRC-1:0]  osc_tick,
  output logic             busy,
  output logic             done,
  output logic [7:0]       cnt_lo,
  output logic [CNT_W-9:0] cnt_hi
);
  ofc_state_e       state;
  logic [1:0]       ref_q;
  logic [PRE_W-1:0] exp_q;
  logic [DIV_W-1:0] div_q;
  logic [SEL_W-1:0] src_q;
  logic [CNT_W-1:0] run_cnt;
  logic [CNT_W-1:0] result;
  logic             accept, ref_hit, opening, adv, closing, src_tick, cnt_inc;

  assign accept   = start && (state == ST_IDLE) &&
                    ((ref_sel == REF_EXT) || (ref_sel == REF_XTAL));
  assign ref_hit  = (ref_q == REF_EXT) ? ext_tick : xtal_tick;
  assign opening  = (state == ST_ARM) && ref_hit;
  assign adv      = (state == ST_GATE) && ref_hit;
  assign cnt_inc  = (state == ST_GATE) && !closing && src_tick;

  ofc_src_mux #(.NSRC(NSRC), .SEL_W(SEL_W)) u_mux (
    .osc_tick (osc_tick),
    .sel      (src_q),
    .tick     (src_tick)
  );

  ofc_gate_timer #(.PRE_W(PRE_W), .DIV_W(DIV_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (opening),
    .adv      (adv),
    .exp_code (exp_q),
    .div_code (div_q),
    .last     (closing)
  );

  ofc_sat_counter #(.W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (opening),
    .inc   (opening ? src_tick : cnt_inc),
    .q     (run_cnt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      ref_q  <= '0;
      exp_q  <= '0;
      div_q  <= '0;
      src_q  <= '0;
      result <= '0;
      done   <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (accept) begin
          state <= ST_ARM;
          ref_q <= ref_sel;
          exp_q <= pre_exp;
          div_q <= div_code;
          src_q <= src_sel;
          done  <= 1'b0;
        end
        ST_ARM:  if (opening) state <= ST_GATE;
        ST_GATE: if (closing) begin
          state  <= ST_IDLE;
          result <= run_cnt;
          done   <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy   = (state != ST_IDLE);
  assign cnt_lo = result[7:0];
  assign cnt_hi = result[CNT_W-1:8];
endmodule

// File: rtl/ofc_checker.sv
module ofc_checker #(
  parameter int SEL_W = 3,
  parameter int NSRC  = 5,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [1:0]       ref_sel,
  input logic             busy,
  input logic             done,
  input logic             gate_on,
  input logic [7:0]       cnt_lo,
  input logic [CNT_W-9:0] cnt_hi,
  input logic [CNT_W-1:0] run_cnt,
  input logic [SEL_W-1:0] src_q
);
  p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && (ref_sel == 2'b01 || ref_sel == 2'b10)) |=> (busy && !done));

  p_ref_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && (ref_sel == 2'b00 || ref_sel == 2'b11)) |=> !busy);

  p_nosrc_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(done) && (src_q == '0 || src_q > SEL_W'(NSRC))) |-> ({cnt_hi, cnt_lo} == '0));

  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_on && $past(gate_on) && ($past(run_cnt) == {CNT_W{1'b1}})) |-> (run_cnt == {CNT_W{1'b1}}));

  p_hold_result_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> $stable({cnt_hi, cnt_lo}));

  p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_done_edge_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $fell(busy));
endmodule

bind osc_gate_counter ofc_checker #(.SEL_W(SEL_W), .NSRC(NSRC), .CNT_W(CNT_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .start   (start),
  .ref_sel (ref_sel),
  .busy    (busy),
  .done    (done),
  .gate_on (state == ofc_pkg::ST_GATE),
  .cnt_lo  (cnt_lo),
  .cnt_hi  (cnt_hi),
  .run_cnt (run_cnt),
  .src_q   (src_q)
);

// File: tb/tb_osc_gate_counter.sv
module tb_osc_gate_counter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [1:0] ref_sel = 2'b10;
  logic [3:0] pre_exp = '0;
  logic [7:0] div_code = '0;
  logic [2:0] src_sel = '0;
  logic       xtal_tick = 1'b0;
  logic       ext_tick = 1'b0;
  logic [4:0] osc_tick = '0;
  logic       busy, done;
  logic [7:0] cnt_lo, cnt_hi;

  int errors = 0;
  int checks = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  osc_gate_counter dut (
    .clk(clk), .rst_n(rst_n), .start(start), .ref_sel(ref_sel),
    .pre_exp(pre_exp), .div_code(div_code), .src_sel(src_sel),
    .xtal_tick(xtal_tick), .ext_tick(ext_tick), .osc_tick(osc_tick),
    .busy(busy), .done(done), .cnt_lo(cnt_lo), .cnt_hi(cnt_hi)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 190000) begin
      $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors + 1, checks + 1);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit pct(input int p);
    return ($urandom_range(99) < p);
  endfunction

  // One measurement, modelled per cycle from the requirements.
  task automatic measure(input logic [1:0] rs, input int n, input int d, input int src,
                         input int ref_pct, input int osc_pct, input bit scramble);
    int  len = (1 << n) * (d + 1);
    int  rem = len;
    int  exp_cnt = 0;
    bit  gating = 0;
    bit  fin = 0;
    bit  mid_checked = 0;
    logic [15:0] prev = {cnt_hi, cnt_lo};
    logic sel_t, o_t;
    @(negedge clk);
    ref_sel = rs; pre_exp = 4'(n); div_code = 8'(d); src_sel = 3'(src);
    start = 1'b1;
    xtal_tick = 1'b1; ext_tick = 1'b1;  // R4: a tick in the start cycle must not open
    osc_tick = 5'h1f;
    @(negedge clk);
    start = 1'b0;
    check("R2 busy after start", busy, 1);
    check("R10 done cleared by start", done, 0);
    if (scramble) begin  // R11: late input changes must not matter
      ref_sel = 2'($urandom); pre_exp = 4'($urandom); div_code = 8'($urandom); src_sel = 3'($urandom);
    end
    while (!fin) begin
      xtal_tick = pct(ref_pct);
      ext_tick  = pct(ref_pct);
      for (int i = 0; i < 5; i++) osc_tick[i] = pct(osc_pct);
      start = scramble && pct(5);  // R2: ignored while busy
      sel_t = (rs == 2'b01) ? ext_tick : xtal_tick;
      o_t = (src >= 1 && src <= 5) ? osc_tick[src-1] : 1'b0;
      if (!gating) begin
        if (sel_t) begin
          gating = 1;
          exp_cnt += o_t;
        end
      end else if (sel_t && (rem == 1)) begin
        fin = 1;
      end else begin
        if (sel_t) rem--;
        exp_cnt += o_t;
      end
      if (exp_cnt > 65535) exp_cnt = 65535;
      @(negedge clk);
      if (!fin && gating && !mid_checked) begin
        mid_checked = 1;
        check("R9 result held during window", {cnt_hi, cnt_lo}, prev);
      end
    end
    start = 1'b0;
    check("R10 done at close", done, 1);
    check("R5 busy low at close", busy, 0);
    check("R6 R7 R8 count low byte", cnt_lo, exp_cnt[7:0]);
    check("R6 R7 R8 count high byte", cnt_hi, exp_cnt[15:8]);
  endtask

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    check("R1 busy reset", busy, 0);
    check("R1 done reset", done, 0);
    check("R1 result reset", {cnt_hi, cnt_lo}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R5: exact window lengths with full-rate reference and oscillator
    measure(2'b10, 0, 0, 1, 100, 100, 0);
    measure(2'b10, 2, 4, 3, 100, 100, 0);
    measure(2'b01, 1, 2, 5, 100, 100, 0);
    // R7: no source selected
    measure(2'b10, 1, 3, 0, 60, 80, 0);
    measure(2'b01, 0, 5, 6, 60, 80, 0);
    measure(2'b10, 2, 1, 7, 60, 80, 0);
    // R3: off and unused reference codes
    for (int k = 0; k < 2; k++) begin
      logic [15:0] held = {cnt_hi, cnt_lo};
      @(negedge clk);
      ref_sel = k ? 2'b11 : 2'b00; src_sel = 3'd1; start = 1'b1;
      xtal_tick = 1'b1; ext_tick = 1'b1; osc_tick = 5'h1f;
      @(negedge clk);
      start = 1'b0;
      repeat (10) @(negedge clk);
      check("R3 busy stays low", busy, 0);
      check("R3 done kept", done, 1);
      check("R3 result kept", {cnt_hi, cnt_lo}, held);
    end
    // largest exponent
    measure(2'b10, 15, 0, 2, 100, 100, 0);
    // R8: 65536-cycle window at full rate saturates
    measure(2'b10, 10, 63, 4, 100, 100, 0);
    // random mix, including R4 foreign-reference ticks and R11 scrambling
    for (int t = 0; t < 30; t++) begin
      measure(($urandom_range(1) != 0) ? 2'b01 : 2'b10,
              $urandom_range(3), $urandom_range(15), $urandom_range(7),
              $urandom_range(20, 90), $urandom_range(10, 100), 1);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule